// File: doc/BRIEF.md
# Core Storage Emulation Sequencer

This block lets a plain word-addressed RAM stand in for the magnetic core storage of an older minicomputer. The host starts a storage cycle with a rising edge on its read strobe. The block captures the address, fetches the word and waits a fixed number of clocks. It then pulls low, for one fixed-width pulse, every sense line whose bit holds a 1. The host's buffer register latches those pulses the way it would latch core sense-amplifier outputs. Bit positions that hold 0 are left released.

Two extra sense lines carry odd parity. One covers each byte of the word, and both are computed from the data just read out of the array. After the read window the block runs a write window. At its last clock the word on the write-data input is stored back at the captured address, completing the read-then-write rhythm of core storage. A lockout lets each cycle fire the sense pulses only once, however the strobe behaves afterwards.

Top module: `core_store_seq`

## Requirements
- R1: A cycle starts only on a clock where `rd_strobe` is high after being low on the previous clock. A strobe held high, or a falling strobe, starts nothing: `busy` stays low and every sense line stays high.
- R2: A sense line whose bit is 1 goes low for exactly `PULSE_W` consecutive clocks. A sense line whose bit is 0 stays high for the whole cycle.
- R3: The first low clock of a sense pulse is exactly `SENSE_DLY+1` clocks after the start edge. No sense line is low at any earlier point of the cycle.
- R4: Each sense line gives at most one pulse per storage cycle. Strobe edges later in the same cycle cause no second pulse.
- R5: Sense line 16 carries odd parity over data bits 7:0, and sense line 17 carries odd parity over bits 15:8. A parity line pulses when its byte holds an even number of ones, and the parity is taken from the word fetched in this cycle.
- R6: `busy` is high for exactly `READ_LEN+WRITE_LEN` clocks, starting the clock after the start edge. A strobe rising edge while `busy` is high is ignored and does not stretch the cycle.
- R7: The address is captured at the start edge. `wr_data` is stored at that address on the last clock of the write window. A later cycle at that address pulses the stored word, even if `addr` changed during the earlier cycle.
- R8: After reset `busy` is low and all sense lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Storage-read strobe; a rising edge starts a cycle |
| addr | input | ADDR_W | Word address, captured at the start edge |
| wr_data | input | DATA_W | Word to store during the write window |
| sense_n | output | DATA_W+DATA_W/8 | Active-low sense pulses: data bits, then one parity line per byte |
| busy | output | 1 | High while a storage cycle is running |

## Verification
A phase counter that slips shows up as a sense pulse at the wrong clock within the first read window. A wrong `busy` length shows up when the cycle ends. A lockout flag that is not cleared shows up as a second falling edge on some sense line later in the same cycle. A bad fetch or write path is seen one cycle later, when the location is read back: wrong data bits pulse, and a mismatched parity line separates a parity fault from a data fault.

// File: rtl/core_store_pkg.sv
package core_store_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  // Odd parity bit for one byte lane: 1 when the lane holds an even count of ones.
  function automatic logic lane_odd_parity(input logic [7:0] lane);
    return ~(^lane);
  endfunction

endpackage

// File: rtl/cs_cycle_timer.sv
module cs_cycle_timer
  import core_store_pkg::*;
#(
  parameter int READ_LEN  = 180,
  parameter int WRITE_LEN = 180,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_strobe,
  output logic             start_evt,
  output logic             fetch_evt,
  output logic             store_evt,
  output logic             in_read,
  output logic [CNT_W-1:0] phase_cnt,
  output logic             busy
);

  phase_e     phase_q;
  logic       strobe_q;
  logic       rise_evt;
  logic       read_last;
  logic       write_last;

  assign rise_evt   = rd_strobe & ~strobe_q;
  assign start_evt  = rise_evt & (phase_q == PH_IDLE);
  assign read_last  = (phase_q == PH_READ)  && (phase_cnt == CNT_W'(READ_LEN - 1));
  assign write_last = (phase_q == PH_WRITE) && (phase_cnt == CNT_W'(WRITE_LEN - 1));
  assign fetch_evt  = (phase_q == PH_READ)  && (phase_cnt == '0);
  assign store_evt  = write_last;
  assign in_read    = (phase_q == PH_READ);
  assign busy       = (phase_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      phase_q   <= PH_IDLE;
      phase_cnt <= '0;
    end else begin
      strobe_q <= rd_strobe;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_evt) begin
            phase_q   <= PH_READ;
            phase_cnt <= '0;
          end
        end
        PH_READ: begin
          if (read_last) begin
            phase_q   <= PH_WRITE;
            phase_cnt <= '0;
          end else begin
            phase_cnt <= phase_cnt + 1'b1;
          end
        end
        PH_WRITE: begin
          if (write_last) begin
            phase_q   <= PH_IDLE;
            phase_cnt <= '0;
          end else begin
            phase_cnt <= phase_cnt + 1'b1;
          end
        end
        default: begin
          phase_q   <= PH_IDLE;
          phase_cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/cs_word_ram.sv
module cs_word_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[word_addr] <= wr_word;
    if (rd_en) rd_word <= cells[word_addr];
  end

endmodule

// File: rtl/cs_sense_pulser.sv
module cs_sense_pulser
  import core_store_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int SENSE_DLY = 40,
  parameter int PULSE_W   = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm_evt,
  input  logic                          in_read,
  input  logic [CNT_W-1:0]              phase_cnt,
  input  logic [DATA_W-1:0]             read_word,
  output logic                          fire_evt,
  output logic                          pulse_active,
  output logic [DATA_W+DATA_W/8-1:0]    sense_n
);

  localparam int LANES   = DATA_W / 8;
  localparam int SENSE_W = DATA_W + LANES;
  localparam int PW_W    = $clog2(PULSE_W + 1);

  logic               armed_q;
  logic [PW_W-1:0]    width_q;
  logic [SENSE_W-1:0] pattern_q;
  logic [LANES-1:0]   lane_par;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_par[l] = lane_odd_parity(read_word[8*l +: 8]);
  end

  assign fire_evt     = armed_q && in_read && (phase_cnt == CNT_W'(SENSE_DLY));
  assign pulse_active = (width_q != '0);
  assign sense_n      = pulse_active ? ~pattern_q : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      width_q   <= '0;
      pattern_q <= '0;
    end else begin
      if (arm_evt) armed_q <= 1'b1;
      else if (fire_evt) armed_q <= 1'b0;

      if (fire_evt) begin
        width_q   <= PW_W'(PULSE_W);
        pattern_q <= {lane_par, read_word};
      end else if (pulse_active) begin
        width_q <= width_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/core_store_seq.sv
module core_store_seq #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int READ_LEN  = 180,
  parameter int WRITE_LEN = 180,
  parameter int SENSE_DLY = 40,
  parameter int PULSE_W   = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_strobe,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W+DATA_W/8-1:0] sense_n,
  output logic                       busy
);

  localparam int MAX_LEN = (READ_LEN > WRITE_LEN) ? READ_LEN : WRITE_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic              start_evt;
  logic              fetch_evt;
  logic              store_evt;
  logic              in_read;
  logic [CNT_W-1:0]  phase_cnt;
  logic              fire_evt;
  logic              pulse_active;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] read_word;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (start_evt) addr_q <= addr;
  end

  cs_cycle_timer #(
    .READ_LEN (READ_LEN),
    .WRITE_LEN(WRITE_LEN),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_strobe(rd_strobe),
    .start_evt(start_evt),
    .fetch_evt(fetch_evt),
    .store_evt(store_evt),
    .in_read  (in_read),
    .phase_cnt(phase_cnt),
    .busy     (busy)
  );

  cs_word_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk      (clk),
    .rd_en    (fetch_evt),
    .wr_en    (store_evt),
    .word_addr(addr_q),
    .wr_word  (wr_data),
    .rd_word  (read_word)
  );

  cs_sense_pulser #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .SENSE_DLY(SENSE_DLY),
    .PULSE_W  (PULSE_W)
  ) u_pulser (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_evt     (start_evt),
    .in_read     (in_read),
    .phase_cnt   (phase_cnt),
    .read_word   (read_word),
    .fire_evt    (fire_evt),
    .pulse_active(pulse_active),
    .sense_n     (sense_n)
  );

endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int SENSE_W = 18,
  parameter int PULSE_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_strobe,
  input logic               start_evt,
  input logic               fire_evt,
  input logic               busy,
  input logic [SENSE_W-1:0] sense_n
);

  localparam int RUN_W = $clog2(PULSE_W + 2) + 1;

  logic [1:0]       fires_q;
  logic [RUN_W-1:0] low_run_q;
  logic             any_low;

  assign any_low = ~(&sense_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fires_q   <= '0;
      low_run_q <= '0;
    end else begin
      if (start_evt) fires_q <= '0;
      else if (fire_evt && fires_q != 2'd3) fires_q <= fires_q + 1'b1;
      if (!any_low) low_run_q <= '0;
      else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
    end
  end

  assert_start_on_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> rd_strobe);

  assert_release_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !any_low);

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= RUN_W'(PULSE_W));

  assert_quiet_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !any_low);

  assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |-> (fires_q == 2'd0));

  assert_start_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !busy);

  assert_busy_follows_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

endmodule

bind core_store_seq cs_checker #(
  .SENSE_W(DATA_W + DATA_W/8),
  .PULSE_W(PULSE_W)
) u_cs_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_strobe(rd_strobe),
  .start_evt(start_evt),
  .fire_evt (fire_evt),
  .busy     (busy),
  .sense_n  (sense_n)
);

// File: tb/core_store_seq_bench.sv
`timescale 1ns/1ps
module core_store_seq_bench;

  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 16;
  localparam int SENSE_W   = DATA_W + DATA_W/8;
  localparam int READ_LEN  = 180;
  localparam int WRITE_LEN = 180;
  localparam int SENSE_DLY = 40;
  localparam int PULSE_W   = 9;
  localparam int TOTAL     = READ_LEN + WRITE_LEN;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rd_strobe = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic [SENSE_W-1:0] sense_n;
  logic               busy;

  int n_total = 0;
  int n_bad   = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] model [64];

  always #10 clk = ~clk;

  core_store_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LEN(READ_LEN),
    .WRITE_LEN(WRITE_LEN), .SENSE_DLY(SENSE_DLY), .PULSE_W(PULSE_W)
  ) u_core_store_seq (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .addr(addr),
    .wr_data(wr_data), .sense_n(sense_n), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sense pattern a correct block must give: data bits, then odd parity per byte.
  function automatic logic [SENSE_W-1:0] expect_pattern(input logic [DATA_W-1:0] w);
    logic [SENSE_W-1:0] p;
    p[DATA_W-1:0] = w;
    for (int l = 0; l < DATA_W/8; l++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(w[8*l + b]);
      p[DATA_W + l] = ((ones % 2) == 0);
    end
    return p;
  endfunction

  // One storage cycle. chk: compare pulses against model. retrig: extra strobe edges
  // while busy. alt_addr >= 0: move addr mid-cycle.
  task automatic storage_cycle(input int a, input logic [DATA_W-1:0] wd,
                               input bit chk, input bit retrig, input int alt_addr);
    int low_cnt [SENSE_W];
    int falls [SENSE_W];
    int first [SENSE_W];
    logic prev [SENSE_W];
    int busy_cnt = 0;
    logic [SENSE_W-1:0] exp_p;
    exp_p = expect_pattern(model[a]);
    for (int i = 0; i < SENSE_W; i++) begin
      low_cnt[i] = 0; falls[i] = 0; first[i] = -1; prev[i] = 1'b1;
    end
    @(negedge clk);
    addr = ADDR_W'(a);
    wr_data = wd;
    rd_strobe = 1'b1;
    for (int k = 0; k < TOTAL + 4; k++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
      for (int i = 0; i < SENSE_W; i++) begin
        if (!sense_n[i]) begin
          low_cnt[i]++;
          if (first[i] < 0) first[i] = k;
        end
        if (prev[i] && !sense_n[i]) falls[i]++;
        prev[i] = sense_n[i];
      end
      if (k == 20) rd_strobe = 1'b0;
      if (retrig && (k == 60 || k == 250)) rd_strobe = 1'b1;
      if (retrig && (k == 70 || k == 260)) rd_strobe = 1'b0;
      if (alt_addr >= 0 && k == 30) addr = ADDR_W'(alt_addr);
    end
    check(busy_cnt == TOTAL, "R6 busy length", busy_cnt, TOTAL);
    if (chk) begin
      for (int i = 0; i < SENSE_W; i++) begin
        if (exp_p[i]) begin
          check(low_cnt[i] == PULSE_W, (i >= DATA_W) ? "R5 parity width" : "R2 R7 width",
                low_cnt[i], PULSE_W);
          check(first[i] == SENSE_DLY + 1, "R3 pulse start", first[i], SENSE_DLY + 1);
          check(falls[i] == 1, "R4 pulse count", falls[i], 1);
        end else begin
          check(low_cnt[i] == 0, (i >= DATA_W) ? "R5 parity idle" : "R2 R7 zero bit",
                low_cnt[i], 0);
        end
      end
    end
    model[a] = wd;
  endtask

  task automatic test_reset();
    check(busy == 1'b0, "R8 busy after reset", int'(busy), 0);
    check(sense_n == '1, "R8 sense after reset", int'(sense_n), int'({SENSE_W{1'b1}}));
  endtask

  task automatic test_fill();
    storage_cycle(0, 16'h0000, 1'b0, 1'b0, -1);
    storage_cycle(1, 16'hFFFF, 1'b0, 1'b0, -1);
    storage_cycle(2, 16'h1234, 1'b0, 1'b0, -1);
    storage_cycle(5, 16'hA5C3, 1'b0, 1'b0, -1);
  endtask

  task automatic test_readback();
    storage_cycle(0, 16'h0101, 1'b1, 1'b0, -1);
    storage_cycle(1, 16'h8001, 1'b1, 1'b0, -1);
    storage_cycle(2, 16'h0000, 1'b1, 1'b0, -1);
    storage_cycle(5, 16'h7F3E, 1'b1, 1'b0, -1);
    storage_cycle(0, 16'h5555, 1'b1, 1'b0, -1);
  endtask

  task automatic test_retrigger_R4();
    storage_cycle(1, 16'h00FF, 1'b1, 1'b1, -1);
    storage_cycle(1, 16'h1111, 1'b1, 1'b0, -1);
  endtask

  task automatic test_addr_hold_R7();
    storage_cycle(2, 16'hC0DE, 1'b1, 1'b0, 9);
    storage_cycle(2, 16'h2222, 1'b1, 1'b0, -1);
    storage_cycle(5, 16'h3333, 1'b1, 1'b0, -1);
  endtask

  task automatic test_level_R1();
    int busy_seen = 0;
    int low_seen = 0;
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    if (busy) begin
      // a rising edge was just made; let that cycle run out under a held strobe
      for (int k = 0; k < TOTAL + 4; k++) @(negedge clk);
    end
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (busy) busy_seen++;
      if (sense_n != '1) low_seen++;
      if (k == 30) rd_strobe = 1'b0;
    end
    check(busy_seen == 0, "R1 level/fall no start busy", busy_seen, 0);
    check(low_seen == 0, "R1 level/fall no start sense", low_seen, 0);
    model[0] = 16'h5555;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fill();
    test_readback();
    test_retrigger_R4();
    test_addr_hold_R7();
    test_level_R1();
    storage_cycle(0, 16'h0F0F, 1'b1, 1'b0, -1);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule